// File: doc/BRIEF.md
# Opcode-Selected Arithmetic and Logic Unit

This block is the execute stage of a small datapath. It takes two operands, X and Y, and a 4-bit operation code. When the valid strobe is high, it computes one of sixteen results and registers it on the clock edge. The result includes bitwise logic on both operands, two's-complement addition and subtraction, and single-operand complement, increment and decrement. Codes with no operation assigned pass X through unchanged.

Alongside the result, the block keeps a 4-bit status register with four flags: zero, carry/borrow, negative and signed overflow. The status register is written only by operations that combine two operands. Single-operand and pass-through codes leave the last flags in place, so a later instruction can still test them. When the strobe is low, both the result and the status hold their values.

Top module: `alu_core`

## Requirements
- R1: While rst_ni is low, result_o and status_o read zero, and they stay zero until the first valid operation.
- R2: Codes 0 to 5 produce bitwise X|Y, X&Y, ~(X&Y), ~(X|Y), X^Y and ~(X^Y), in that order.
- R3: Code 6 produces (X+Y) mod 256. The carry flag is the unsigned carry-out, and the overflow flag is set when X and Y share a sign that the sum does not.
- R4: Code 7 produces (X-Y) mod 256. The carry flag is the borrow (X<Y unsigned), and the overflow flag is set when X and Y differ in sign and the difference's sign differs from X.
- R5: Code 8 produces ~X, code 9 produces X+1 and code 10 produces X-1, each wrapping modulo 256.
- R6: Codes 11 to 15 produce X unchanged.
- R7: The status bits are: bit 0 zero (result is 0), bit 1 carry/borrow, bit 2 negative (result bit 7), bit 3 overflow. Codes 0 to 5 clear bits 1 and 3.
- R8: The status register is written only for codes 0 to 7. Codes 8 to 15 leave it exactly as it was.
- R9: Both outputs update on the rising clock edge where valid_i is high and appear after that edge. While valid_i is low, both outputs hold regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe; outputs update on this edge |
| opcode_i | input | 4 | Operation select |
| x_i | input | 8 | Operand X |
| y_i | input | 8 | Operand Y |
| result_o | output | 8 | Registered result |
| status_o | output | 4 | Registered flags {overflow, negative, carry, zero} |

## Verification
The bench aims at the signed and unsigned edges of the adder and subtractor: 7F+01, FF+01, 00-01, 80-01 and equal operands. A design with swapped carry/overflow logic or a borrow of the wrong polarity reports wrong flags on exactly these values. Increment of FF and decrement of 00 are placed directly after flag-setting operations, so a design that lets single-operand codes touch the status register shows changed flags. The bench also drives idle cycles with different operands on the inputs. A design that ignores the strobe shows a new result in those cycles.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W = 4;
  localparam int unsigned ST_W = 4;

  localparam logic [OP_W-1:0] OP_OR   = 4'h0;
  localparam logic [OP_W-1:0] OP_AND  = 4'h1;
  localparam logic [OP_W-1:0] OP_NAND = 4'h2;
  localparam logic [OP_W-1:0] OP_NOR  = 4'h3;
  localparam logic [OP_W-1:0] OP_XOR  = 4'h4;
  localparam logic [OP_W-1:0] OP_XNOR = 4'h5;
  localparam logic [OP_W-1:0] OP_ADD  = 4'h6;
  localparam logic [OP_W-1:0] OP_SUB  = 4'h7;
  localparam logic [OP_W-1:0] OP_NOT  = 4'h8;
  localparam logic [OP_W-1:0] OP_INC  = 4'h9;
  localparam logic [OP_W-1:0] OP_DEC  = 4'hA;

  // bit order is part of the port contract
  typedef struct packed {
    logic ovf;
    logic neg;
    logic cry;
    logic zero;
  } alu_status_t;

  function automatic logic is_dyadic(input logic [OP_W-1:0] op);
    return (op <= OP_SUB);
  endfunction
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] or_o,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] nand_o,
  output logic [DATA_W-1:0] nor_o,
  output logic [DATA_W-1:0] xor_o,
  output logic [DATA_W-1:0] xnor_o,
  output logic [DATA_W-1:0] not_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign or_o[i]   = a_i[i] | b_i[i];
    assign and_o[i]  = a_i[i] & b_i[i];
    assign nand_o[i] = ~(a_i[i] & b_i[i]);
    assign nor_o[i]  = ~(a_i[i] | b_i[i]);
    assign xor_o[i]  = a_i[i] ^ b_i[i];
    assign xnor_o[i] = ~(a_i[i] ^ b_i[i]);
    assign not_o[i]  = ~a_i[i];
  end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              sum_c_o,
  output logic              sum_v_o,
  output logic [DATA_W-1:0] dif_o,
  output logic              dif_b_o,
  output logic              dif_v_o,
  output logic [DATA_W-1:0] inc_o,
  output logic [DATA_W-1:0] dec_o
);
  localparam int unsigned MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W:0] sum_w;
  logic [DATA_W:0] dif_w;

  assign sum_w = {1'b0, a_i} + {1'b0, b_i};
  assign dif_w = {1'b0, a_i} - {1'b0, b_i};

  assign sum_o   = sum_w[MSB:0];
  assign sum_c_o = sum_w[DATA_W];
  assign sum_v_o = (a_i[MSB] == b_i[MSB]) && (sum_w[MSB] != a_i[MSB]);

  // top bit of widened difference is set exactly when a < b
  assign dif_o   = dif_w[MSB:0];
  assign dif_b_o = dif_w[DATA_W];
  assign dif_v_o = (a_i[MSB] != b_i[MSB]) && (dif_w[MSB] != a_i[MSB]);

  assign inc_o = a_i + ONE;
  assign dec_o = a_i - ONE;
endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] or_i,
  input  logic [DATA_W-1:0] and_i,
  input  logic [DATA_W-1:0] nand_i,
  input  logic [DATA_W-1:0] nor_i,
  input  logic [DATA_W-1:0] xor_i,
  input  logic [DATA_W-1:0] xnor_i,
  input  logic [DATA_W-1:0] not_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic              sum_c_i,
  input  logic              sum_v_i,
  input  logic [DATA_W-1:0] dif_i,
  input  logic              dif_b_i,
  input  logic              dif_v_i,
  input  logic [DATA_W-1:0] inc_i,
  input  logic [DATA_W-1:0] dec_i,
  output logic [DATA_W-1:0] res_o,
  output alu_status_t       flags_o,
  output logic              dyadic_o
);
  logic cry, ovf;

  always_comb begin
    cry = 1'b0;
    ovf = 1'b0;
    case (op_i)
      OP_OR:   res_o = or_i;
      OP_AND:  res_o = and_i;
      OP_NAND: res_o = nand_i;
      OP_NOR:  res_o = nor_i;
      OP_XOR:  res_o = xor_i;
      OP_XNOR: res_o = xnor_i;
      OP_ADD: begin
        res_o = sum_i;
        cry   = sum_c_i;
        ovf   = sum_v_i;
      end
      OP_SUB: begin
        res_o = dif_i;
        cry   = dif_b_i;
        ovf   = dif_v_i;
      end
      OP_NOT:  res_o = not_i;
      OP_INC:  res_o = inc_i;
      OP_DEC:  res_o = dec_i;
      default: res_o = x_i;
    endcase
  end

  assign flags_o.zero = (res_o == '0);
  assign flags_o.neg  = res_o[DATA_W-1];
  assign flags_o.cry  = cry;
  assign flags_o.ovf  = ovf;
  assign dyadic_o     = is_dyadic(op_i);
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        opcode_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [DATA_W-1:0] result_o,
  output logic [3:0]        status_o
);
  logic [DATA_W-1:0] or_w, and_w, nand_w, nor_w, xor_w, xnor_w, not_w;
  logic [DATA_W-1:0] sum_w, dif_w, inc_w, dec_w, res_w;
  logic              sum_c, sum_v, dif_b, dif_v, dyadic;
  alu_status_t       flags_w, status_q;
  logic [DATA_W-1:0] result_q;

  alu_logic_unit #(.DATA_W(DATA_W)) u_logic (
    .a_i(x_i), .b_i(y_i),
    .or_o(or_w), .and_o(and_w), .nand_o(nand_w), .nor_o(nor_w),
    .xor_o(xor_w), .xnor_o(xnor_w), .not_o(not_w)
  );

  alu_arith_unit #(.DATA_W(DATA_W)) u_arith (
    .a_i(x_i), .b_i(y_i),
    .sum_o(sum_w), .sum_c_o(sum_c), .sum_v_o(sum_v),
    .dif_o(dif_w), .dif_b_o(dif_b), .dif_v_o(dif_v),
    .inc_o(inc_w), .dec_o(dec_w)
  );

  alu_result_sel #(.DATA_W(DATA_W)) u_sel (
    .op_i(opcode_i), .x_i(x_i),
    .or_i(or_w), .and_i(and_w), .nand_i(nand_w), .nor_i(nor_w),
    .xor_i(xor_w), .xnor_i(xnor_w), .not_i(not_w),
    .sum_i(sum_w), .sum_c_i(sum_c), .sum_v_i(sum_v),
    .dif_i(dif_w), .dif_b_i(dif_b), .dif_v_i(dif_v),
    .inc_i(inc_w), .dec_i(dec_w),
    .res_o(res_w), .flags_o(flags_w), .dyadic_o(dyadic)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      status_q <= '0;
    end else if (valid_i) begin
      result_q <= res_w;
      if (dyadic) status_q <= flags_w;
    end
  end

  assign result_o = result_q;
  assign status_o = status_q;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        opcode_i,
  input logic [DATA_W-1:0] x_i,
  input logic [DATA_W-1:0] y_i,
  input logic [DATA_W-1:0] result_o,
  input logic [3:0]        status_o
);
  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(status_o)));

  assert_status_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i >= 4'h8) |=> $stable(status_o));

  assert_neg_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i <= 4'h7) |=> (status_o[2] == result_o[DATA_W-1]));

  assert_zero_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i <= 4'h7) |=> (status_o[0] == (result_o == '0)));

  assert_logic_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i <= 4'h5) |=> (!status_o[1] && !status_o[3]));

  assert_add_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == 4'h6) |=> (result_o == ($past(x_i) + $past(y_i))));

  assert_pass_x_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i >= 4'hB) |=> (result_o == $past(x_i)));
endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .opcode_i(opcode_i),
  .x_i(x_i), .y_i(y_i), .result_o(result_o), .status_o(status_o)
);

// File: tb/alu_core_tb.sv
`timescale 1ns/1ps
module alu_core_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] opcode_i = '0;
  logic [7:0] x_i = '0;
  logic [7:0] y_i = '0;
  logic [7:0] result_o;
  logic [3:0] status_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] res;
    logic [3:0] st;
    string      tag;
  } exp_t;

  exp_t sb[$];
  logic [7:0] m_res = '0;
  logic [3:0] m_st = '0;

  always #10 clk_i = ~clk_i;

  alu_core u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .opcode_i(opcode_i),
    .x_i(x_i), .y_i(y_i), .result_o(result_o), .status_o(status_o)
  );

  task automatic check(input string tag, input logic [7:0] ar, input logic [3:0] as_,
                       input logic [7:0] er, input logic [3:0] es);
    total++;
    if (ar !== er || as_ !== es) begin
      bad++;
      $display("FAIL %s actual res=%h st=%b expected res=%h st=%b", tag, ar, as_, er, es);
    end
  endtask

  // bench model: status bits {ovf,neg,cry,zero}
  task automatic drive(input logic v, input logic [3:0] op, input logic [7:0] x,
                       input logic [7:0] y, input string tag);
    logic [8:0] wide;
    logic [7:0] r;
    logic c, o;
    exp_t e;
    @(negedge clk_i);
    valid_i = v; opcode_i = op; x_i = x; y_i = y;
    c = 1'b0; o = 1'b0;
    case (op)
      4'h0: r = x | y;
      4'h1: r = x & y;
      4'h2: r = ~(x & y);
      4'h3: r = ~(x | y);
      4'h4: r = x ^ y;
      4'h5: r = ~(x ^ y);
      4'h6: begin
        wide = {1'b0, x} + {1'b0, y}; r = wide[7:0]; c = wide[8];
        o = ($signed(x) + $signed(y) > 127) || ($signed(x) + $signed(y) < -128);
      end
      4'h7: begin
        r = x - y; c = (x < y);
        o = ($signed(x) - $signed(y) > 127) || ($signed(x) - $signed(y) < -128);
      end
      4'h8: r = ~x;
      4'h9: r = x + 8'd1;
      4'hA: r = x - 8'd1;
      default: r = x;
    endcase
    if (v) begin
      m_res = r;
      if (op <= 4'h7) m_st = {o, r[7], c, (r == 8'h00)};
    end
    e.res = m_res; e.st = m_st; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: an item pushed before a rising edge is compared at the next falling edge
  initial begin
    bit due;
    forever begin
      @(posedge clk_i);
      due = rst_ni && (sb.size() > 0);
      @(negedge clk_i);
      if (due) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, result_o, status_o, e.res, e.st);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R9 actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    x_i = 8'hAA; y_i = 8'h55; opcode_i = 4'h6; valid_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    check("R1 in reset", result_o, status_o, 8'h00, 4'h0);
    valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", result_o, status_o, 8'h00, 4'h0);

    drive(1, 4'h0, 8'h00, 8'h09, "R2 or");
    drive(1, 4'h1, 8'h09, 8'h05, "R2 and");
    drive(1, 4'h2, 8'h05, 8'h05, "R2 nand");
    drive(1, 4'h3, 8'h00, 8'h08, "R2 nor");
    drive(1, 4'h4, 8'hF0, 8'hF0, "R2 xor zero R7");
    drive(1, 4'h5, 8'h00, 8'h08, "R2 xnor");
    drive(1, 4'h6, 8'h7F, 8'h01, "R3 signed overflow R7");
    drive(1, 4'h0, 8'h01, 8'h00, "R7 logic clears carry/ovf");
    drive(1, 4'h6, 8'hFF, 8'h01, "R3 carry out zero");
    drive(1, 4'h6, 8'h80, 8'h80, "R3 carry and overflow");
    drive(1, 4'h6, 8'h12, 8'h34, "R3 plain");
    drive(1, 4'h7, 8'h00, 8'h01, "R4 borrow");
    drive(1, 4'h7, 8'h80, 8'h01, "R4 overflow");
    drive(1, 4'h7, 8'h05, 8'h05, "R4 equal");
    drive(1, 4'h7, 8'h7F, 8'hFF, "R4 overflow borrow");
    drive(1, 4'h9, 8'hFF, 8'h00, "R5 inc wrap R8 status kept");
    drive(1, 4'hA, 8'h00, 8'h00, "R5 dec wrap R8 status kept");
    drive(1, 4'h8, 8'h3C, 8'h11, "R5 not R8 status kept");
    drive(1, 4'h6, 8'h01, 8'h01, "R3 flags clear");
    drive(1, 4'hA, 8'h01, 8'h00, "R5 dec to zero R8 no zero flag");
    for (int k = 11; k < 16; k++)
      drive(1, 4'(k), 8'(8'hA0 + k), 8'hFF, "R6 pass x R8");
    drive(1, 4'h6, 8'hFF, 8'hFF, "R3 carry negative");
    drive(0, 4'h7, 8'h00, 8'h01, "R9 idle hold");
    drive(0, 4'h0, 8'h55, 8'hAA, "R9 idle hold");
    drive(0, 4'h9, 8'h10, 8'h00, "R9 idle hold");
    drive(1, 4'h4, 8'h0F, 8'hF5, "R9 resume R2");
    drive(0, 4'h4, 8'h00, 8'h00, "R9 idle after");
    repeat (3) @(negedge clk_i);
    valid_i = 1'b0;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule